// File: doc/BRIEF.md
# Address Table Clear and Aging Engine

This block owns a small address lookup table and carries out the two maintenance jobs software starts on it. The first is a full wipe. The second is an aging sweep that releases stale entries. Each table entry holds a key field and three flags: in use, may age, and recently hit. Software reaches the block through a simple request/ready register port. The same port gives direct read and write access to individual table entries.

A wipe zeroes the entire table and holds the port off for a fixed number of clocks. An aging sweep runs in the background and does not block the port. It walks the entries from index 0 upward and spends four clocks on each one. The sweep marks as unused every entry that may age and has not been hit. Static entries, whose may-age flag is 0, are always kept. A packet-processing contender is modelled as a single request line. That request takes the table's memory port ahead of software table accesses and ahead of the sweep.

Top module: `lut_maint_engine`

## Requirements
- R1: A wipe leaves every bit of every table entry at zero.
- R2: `ready` is low for exactly CLR_CYCLES (64) consecutive cycles. These cycles start at the clock edge that accepts the wipe command. No register or table access is accepted during them, and a held read completes right after.
- R3: Control register bit 0 is the wipe command, started by writing 1. This bit always reads back 0, including on a read that was held through a wipe.
- R4: Each entry is `{in_use[KEY_W+2], may_age[KEY_W+1], hit[KEY_W], key[KEY_W-1:0]}`. A sweep clears `in_use` on every entry with may_age=1 and hit=0, and leaves all other bits of every entry unchanged.
- R5: Control register bit 1 is the sweep command, started by writing 1. It reads 1 while the sweep runs and returns to 0 by itself when the sweep ends.
- R6: With `pkt_req` held low, a sweep keeps bit 1 set for exactly 4×DEPTH cycles.
- R7: An entry with may_age=0 is never released by a sweep.
- R8: `pkt_gnt` follows `pkt_req` except during a wipe, when it stays low. While `pkt_req` is high, the sweep holds its place, and the sweep gets longer by exactly the number of cycles it was held.
- R9: A sweep command written while a sweep is running is ignored. The sweep keeps its original length and its result.
- R10: A wipe command aborts a running sweep. Afterwards bit 1 reads 0 and the table is all zero.
- R11: An address with bit IW set selects table entry `addr[IW-1:0]` for reading and writing. An address with bit IW clear selects the control register. A table access is held off (`ready` low) while `pkt_req` is high.
- R12: After reset, `ready` is high, `pkt_gnt` is low and the control register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | IW+1 | Bit IW selects the table, lower bits give the entry index |
| wdata | input | KEY_W+3 | Write data (an entry, or the control command bits) |
| ready | output | 1 | An access is taken on an edge where `req` and `ready` are both high |
| rdata | output | KEY_W+3 | Read result, valid from the edge after the read is accepted |
| pkt_req | input | 1 | Packet-processing request for the table memory port |
| pkt_gnt | output | 1 | Memory port granted to packet processing |

## Verification
The hardest situations to reach are a sweep that is stalled mid-way, re-commanded, or cut short by a wipe, because none of these is visible at the ports except as the length of the busy window. The bench polls the control register on every cycle and counts the busy cycles exactly. It holds `pkt_req` high for a known span from the first clock of a sweep, which keeps the sweep parked on entry 0. It also slips a second sweep write into the polling stream, and in a separate run it issues a wipe part-way through a sweep. The table is loaded so that every combination of the three flags appears many times. After each sweep, every entry is read back and compared with a value the bench computes from the flag rule.

// File: rtl/lut_maint_pkg.sv
package lut_maint_pkg;

  // Control register command bit positions (software-visible encoding)
  localparam int CTRL_CLR_BIT = 0;
  localparam int CTRL_AGE_BIT = 1;

  // Per-entry sub-steps of the aging sweep
  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_JUDGE = 2'd1,
    PH_STORE = 2'd2,
    PH_STEP  = 2'd3
  } age_phase_e;

  // Memory port owner
  typedef enum logic [2:0] {
    OWN_NONE  = 3'd0,
    OWN_CLEAR = 3'd1,
    OWN_PKT   = 3'd2,
    OWN_SW    = 3'd3,
    OWN_SCAN  = 3'd4
  } port_owner_e;

endpackage

// File: rtl/lut_maint_mem.sv
module lut_maint_mem #(
  parameter int DEPTH = 64,
  parameter int EW    = 11,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [EW-1:0] wr_data,
  output logic [EW-1:0] rd_data
);

  logic [EW-1:0] cell_vec [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic          cell_en;
    logic [EW-1:0] cell_q;

    assign cell_en = wr_en && (idx == IW'(g));

    always_ff @(posedge clk) begin
      if (cell_en) begin
        cell_q <= wr_data;
      end
    end

    assign cell_vec[g] = cell_q;
  end

  assign rd_data = cell_vec[idx];

endmodule

// File: rtl/lut_maint_port.sv
module lut_maint_port
  import lut_maint_pkg::*;
#(
  parameter int IW = 6,
  parameter int EW = 11
) (
  // wipe walker
  input  logic          clearing,
  input  logic [IW-1:0] clr_idx,
  input  logic          clr_we,
  // packet contender
  input  logic          pkt_req,
  // software table access
  input  logic          sw_tbl,
  input  logic          sw_we,
  input  logic [IW-1:0] sw_idx,
  input  logic [EW-1:0] sw_wdata,
  // aging sweep
  input  logic          scan_want,
  input  logic [IW-1:0] scan_idx,
  input  logic          scan_we,
  input  logic [EW-1:0] scan_wdata,
  // grants and memory side
  output logic          pkt_gnt,
  output logic          sw_gnt,
  output logic          scan_gnt,
  output logic          mem_we,
  output logic [IW-1:0] mem_idx,
  output logic [EW-1:0] mem_wdata
);

  port_owner_e owner;

  // Fixed priority: wipe, packet, software, sweep
  always_comb begin
    if (clearing) begin
      owner = OWN_CLEAR;
    end else if (pkt_req) begin
      owner = OWN_PKT;
    end else if (sw_tbl) begin
      owner = OWN_SW;
    end else if (scan_want) begin
      owner = OWN_SCAN;
    end else begin
      owner = OWN_NONE;
    end
  end

  assign pkt_gnt  = (owner == OWN_PKT);
  assign sw_gnt   = (owner == OWN_SW);
  assign scan_gnt = (owner == OWN_SCAN);

  always_comb begin
    mem_we    = 1'b0;
    mem_idx   = scan_idx;
    mem_wdata = scan_wdata;
    case (owner)
      OWN_CLEAR: begin
        mem_we    = clr_we;
        mem_idx   = clr_idx;
        mem_wdata = '0;
      end
      OWN_SW: begin
        mem_we    = sw_we;
        mem_idx   = sw_idx;
        mem_wdata = sw_wdata;
      end
      OWN_SCAN: begin
        mem_we    = scan_we;
        mem_idx   = scan_idx;
        mem_wdata = scan_wdata;
      end
      default: begin
        mem_we    = 1'b0;
        mem_idx   = scan_idx;
        mem_wdata = scan_wdata;
      end
    endcase
  end

endmodule

// File: rtl/lut_maint_seq.sv
module lut_maint_seq
  import lut_maint_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int KEY_W      = 8,
  parameter int CLR_CYCLES = 64,
  localparam int IW        = $clog2(DEPTH),
  localparam int EW        = KEY_W + 3,
  localparam int CW        = $clog2(CLR_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_start,
  input  logic          age_start,
  input  logic          scan_gnt,
  input  logic [EW-1:0] rd_data,
  output logic          clearing,
  output logic [IW-1:0] clr_idx,
  output logic          clr_we,
  output logic          age_busy,
  output age_phase_e    phase,
  output logic          scan_want,
  output logic [IW-1:0] scan_idx,
  output logic          scan_we,
  output logic [EW-1:0] scan_wdata
);

  localparam int           USE_BIT  = KEY_W + 2;
  localparam int           AGE_BIT  = KEY_W + 1;
  localparam int           HIT_BIT  = KEY_W;
  localparam logic [CW-1:0] CLR_LAST = CW'(CLR_CYCLES - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(DEPTH - 1);

  logic          clearing_q, clearing_d;
  logic [CW-1:0] clr_cnt_q, clr_cnt_d;
  logic          busy_q, busy_d;
  age_phase_e    phase_q, phase_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [EW-1:0] snap_q, snap_d;
  logic          doom_q, doom_d;
  logic          snap_en;

  // next-state
  always_comb begin
    clearing_d = clearing_q;
    clr_cnt_d  = clr_cnt_q;
    busy_d     = busy_q;
    phase_d    = phase_q;
    idx_d      = idx_q;
    snap_d     = snap_q;
    doom_d     = doom_q;
    snap_en    = 1'b0;

    if (clr_start) begin
      // a wipe always wins and abandons any sweep in flight
      clearing_d = 1'b1;
      clr_cnt_d  = '0;
      busy_d     = 1'b0;
      phase_d    = PH_FETCH;
      idx_d      = '0;
    end else if (clearing_q) begin
      clr_cnt_d = clr_cnt_q + 1'b1;
      if (clr_cnt_q == CLR_LAST) begin
        clearing_d = 1'b0;
      end
    end else if (busy_q) begin
      case (phase_q)
        PH_FETCH: begin
          if (scan_gnt) begin
            snap_d  = rd_data;
            snap_en = 1'b1;
            phase_d = PH_JUDGE;
          end
        end
        PH_JUDGE: begin
          doom_d  = snap_q[AGE_BIT] && !snap_q[HIT_BIT];
          phase_d = PH_STORE;
        end
        PH_STORE: begin
          if (!doom_q || scan_gnt) begin
            phase_d = PH_STEP;
          end
        end
        default: begin
          phase_d = PH_FETCH;
          if (idx_q == IDX_LAST) begin
            busy_d = 1'b0;
            idx_d  = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      endcase
    end else if (age_start) begin
      busy_d  = 1'b1;
      phase_d = PH_FETCH;
      idx_d   = '0;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clearing_q <= 1'b0;
      clr_cnt_q  <= '0;
      busy_q     <= 1'b0;
      phase_q    <= PH_FETCH;
      idx_q      <= '0;
      doom_q     <= 1'b0;
    end else begin
      clearing_q <= clearing_d;
      clr_cnt_q  <= clr_cnt_d;
      busy_q     <= busy_d;
      phase_q    <= phase_d;
      idx_q      <= idx_d;
      doom_q     <= doom_d;
    end
  end

  // datapath snapshot, enabled only on a granted fetch
  always_ff @(posedge clk) begin
    if (snap_en) begin
      snap_q <= snap_d;
    end
  end

  assign clearing   = clearing_q;
  assign clr_idx    = IW'(clr_cnt_q);
  assign clr_we     = clearing_q && (int'(clr_cnt_q) < DEPTH);
  assign age_busy   = busy_q;
  assign phase      = phase_q;
  assign scan_idx   = idx_q;
  assign scan_want  = busy_q &&
                      ((phase_q == PH_FETCH) || ((phase_q == PH_STORE) && doom_q));
  // write back only if software left the entry alone since the fetch
  assign scan_we    = (phase_q == PH_STORE) && doom_q && (rd_data == snap_q);
  assign scan_wdata = rd_data & ~(EW'(1) << USE_BIT);

endmodule

// File: rtl/lut_maint_engine.sv
module lut_maint_engine
  import lut_maint_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int KEY_W      = 8,
  parameter int CLR_CYCLES = 64,
  localparam int IW        = $clog2(DEPTH),
  localparam int EW        = KEY_W + 3,
  localparam int AW        = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [EW-1:0] wdata,
  output logic          ready,
  output logic [EW-1:0] rdata,
  input  logic          pkt_req,
  output logic          pkt_gnt
);

  // reset release synchronizer
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  // internal nets
  logic          clearing;
  logic [IW-1:0] clr_idx;
  logic          clr_we;
  logic          age_busy;
  age_phase_e    phase;
  logic          scan_want;
  logic [IW-1:0] scan_idx;
  logic          scan_we;
  logic [EW-1:0] scan_wdata;
  logic          sw_gnt;
  logic          scan_gnt;
  logic          mem_we;
  logic [IW-1:0] mem_idx;
  logic [EW-1:0] mem_wdata;
  logic [EW-1:0] mem_rd;

  // access decode
  logic          is_tbl;
  logic          sw_tbl;
  logic          accept;
  logic          ctrl_wr;
  logic          clr_start;
  logic          age_start;
  logic [EW-1:0] ctrl_word;
  logic          rd_load;
  logic [EW-1:0] rdata_d, rdata_q;

  assign is_tbl    = addr[AW-1];
  assign sw_tbl    = req && is_tbl;
  assign ready     = !clearing && (!is_tbl || sw_gnt);
  assign accept    = req && ready;
  assign ctrl_wr   = accept && we && !is_tbl;
  assign clr_start = ctrl_wr && wdata[CTRL_CLR_BIT];
  assign age_start = ctrl_wr && wdata[CTRL_AGE_BIT] && !wdata[CTRL_CLR_BIT];
  assign ctrl_word = EW'(age_busy) << CTRL_AGE_BIT;

  assign rd_load = accept && !we;
  assign rdata_d = is_tbl ? mem_rd : ctrl_word;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (rd_load) begin
      rdata_q <= rdata_d;
    end
  end
  assign rdata = rdata_q;

  lut_maint_seq #(
    .DEPTH      (DEPTH),
    .KEY_W      (KEY_W),
    .CLR_CYCLES (CLR_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr_start  (clr_start),
    .age_start  (age_start),
    .scan_gnt   (scan_gnt),
    .rd_data    (mem_rd),
    .clearing   (clearing),
    .clr_idx    (clr_idx),
    .clr_we     (clr_we),
    .age_busy   (age_busy),
    .phase      (phase),
    .scan_want  (scan_want),
    .scan_idx   (scan_idx),
    .scan_we    (scan_we),
    .scan_wdata (scan_wdata)
  );

  lut_maint_port #(
    .IW (IW),
    .EW (EW)
  ) u_port (
    .clearing   (clearing),
    .clr_idx    (clr_idx),
    .clr_we     (clr_we),
    .pkt_req    (pkt_req),
    .sw_tbl     (sw_tbl),
    .sw_we      (we),
    .sw_idx     (addr[IW-1:0]),
    .sw_wdata   (wdata),
    .scan_want  (scan_want),
    .scan_idx   (scan_idx),
    .scan_we    (scan_we),
    .scan_wdata (scan_wdata),
    .pkt_gnt    (pkt_gnt),
    .sw_gnt     (sw_gnt),
    .scan_gnt   (scan_gnt),
    .mem_we     (mem_we),
    .mem_idx    (mem_idx),
    .mem_wdata  (mem_wdata)
  );

  lut_maint_mem #(
    .DEPTH (DEPTH),
    .EW    (EW)
  ) u_mem (
    .clk     (clk),
    .wr_en   (mem_we),
    .idx     (mem_idx),
    .wr_data (mem_wdata),
    .rd_data (mem_rd)
  );

endmodule

// File: rtl/lut_maint_chk.sv
module lut_maint_chk
  import lut_maint_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int KEY_W      = 8,
  parameter int CLR_CYCLES = 64,
  localparam int IW        = $clog2(DEPTH),
  localparam int EW        = KEY_W + 3,
  localparam int AW        = IW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic          ready,
  input logic [EW-1:0] rdata,
  input logic          pkt_req,
  input logic          clearing,
  input logic          age_busy,
  input age_phase_e    phase,
  input logic [IW-1:0] scan_idx
);

  int clr_run;
  int age_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_run <= 0;
      age_run <= 0;
    end else begin
      clr_run <= clearing ? clr_run + 1 : 0;
      age_run <= age_busy ? age_run + 1 : 0;
    end
  end

  p_hold_in_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> !ready);

  p_clear_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clearing) |-> (clr_run == CLR_CYCLES));

  p_clr_bit_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req && ready && !we && !addr[AW-1]) |-> !rdata[CTRL_CLR_BIT]);

  p_pass_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(age_busy) && !clearing) |-> (age_run >= 4 * DEPTH));

  p_scan_parks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_busy && !clearing && pkt_req && phase == PH_FETCH)
      |=> (clearing || (phase == PH_FETCH && $stable(scan_idx))));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_busy && $past(age_busy)) |-> (scan_idx >= $past(scan_idx)));

  p_clear_aborts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> !age_busy);

endmodule

bind lut_maint_engine lut_maint_chk #(
  .DEPTH      (DEPTH),
  .KEY_W      (KEY_W),
  .CLR_CYCLES (CLR_CYCLES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .req      (req),
  .we       (we),
  .addr     (addr),
  .ready    (ready),
  .rdata    (rdata),
  .pkt_req  (pkt_req),
  .clearing (clearing),
  .age_busy (age_busy),
  .phase    (phase),
  .scan_idx (scan_idx)
);

// File: tb/lut_maint_engine_test.sv
module lut_maint_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int KEY_W      = 8;
  localparam int CLR_CYCLES = 64;
  localparam int IW         = $clog2(DEPTH);
  localparam int EW         = KEY_W + 3;
  localparam int AW         = IW + 1;

  logic          clk, rst_n, req, we, ready, pkt_req, pkt_gnt;
  logic [AW-1:0] addr;
  logic [EW-1:0] wdata, rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  lut_maint_engine #(
    .DEPTH (DEPTH), .KEY_W (KEY_W), .CLR_CYCLES (CLR_CYCLES)
  ) uut (
    .clk (clk), .rst_n (rst_n), .req (req), .we (we), .addr (addr),
    .wdata (wdata), .ready (ready), .rdata (rdata),
    .pkt_req (pkt_req), .pkt_gnt (pkt_gnt)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // entry = {in_use, may_age, hit, key}; flags sweep all 8 combinations
  function automatic logic [EW-1:0] pat(input int i, input int salt);
    logic [2:0]       f;
    logic [KEY_W-1:0] k;
    f = 3'((i + salt) % 8);
    k = KEY_W'(i * 7 + salt * 13);
    return {f, k};
  endfunction

  function automatic logic [EW-1:0] aged(input logic [EW-1:0] e);
    logic [EW-1:0] r;
    r = e;
    if (e[EW-2] && !e[EW-3]) r[EW-1] = 1'b0;
    return r;
  endfunction

  function automatic logic [AW-1:0] tbl(input int i);
    return {1'b1, IW'(i)};
  endfunction

  task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [EW-1:0] d,
                      output logic [EW-1:0] q);
    bit done;
    done = 0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    while (!done) begin
      #1;
      done = ready;
      @(posedge clk);
      if (!done) @(negedge clk);
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    q = rdata;
  endtask

  task automatic fill(input int salt);
    logic [EW-1:0] q;
    for (int i = 0; i < DEPTH; i++) xfer(1'b1, tbl(i), pat(i, salt), q);
  endtask

  // mode 0: as written, 1: after sweep, 2: all zero
  task automatic verify(input int salt, input int mode, input string tag);
    logic [EW-1:0] q, e;
    for (int i = 0; i < DEPTH; i++) begin
      xfer(1'b0, tbl(i), '0, q);
      e = (mode == 0) ? pat(i, salt) : (mode == 1) ? aged(pat(i, salt)) : '0;
      check(q == e, tag, int'(q), int'(e));
    end
  endtask

  // R7: entries with may_age=0 keep their in_use flag
  task automatic verify_static(input int salt);
    logic [EW-1:0] q, e;
    int bad;
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      e = pat(i, salt);
      if (!e[EW-2]) begin
        xfer(1'b0, tbl(i), '0, q);
        if (q[EW-1] != e[EW-1]) bad++;
      end
    end
    check(bad == 0, "R7 static entries kept", bad, 0);
  endtask

  // called right after the command edge; returns read-observed busy cycles
  task automatic poll_busy(input int stall, input int rewrite_at, output int n);
    n = 0;
    req = 1'b1; we = 1'b0; addr = '0; wdata = '0;
    if (stall > 0) pkt_req = 1'b1;
    for (int k = 1; k < 4000; k++) begin
      @(negedge clk);
      if (k == 1 && stall > 0) check(pkt_gnt == 1'b1, "R8 pkt_gnt follows", int'(pkt_gnt), 1);
      if (!rdata[1]) break;
      n++;
      if (k == stall) pkt_req = 1'b0;
      if (k == rewrite_at) begin we = 1'b1; wdata = EW'(2); end
      else begin we = 1'b0; wdata = '0; end
    end
    req = 1'b0; we = 1'b0; pkt_req = 1'b0;
  endtask

  // called right after the wipe command edge; holds a control read through it
  task automatic measure_clear(output int n, output logic [EW-1:0] q);
    n = 0;
    req = 1'b1; we = 1'b0; addr = '0;
    while (1) begin
      #1;
      if (ready) break;
      n++;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    q = rdata;
  endtask

  initial begin
    logic [EW-1:0] q;
    int n;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; pkt_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    check(ready == 1'b1, "R12 ready after reset", int'(ready), 1);
    check(pkt_gnt == 1'b0, "R12 pkt_gnt after reset", int'(pkt_gnt), 0);
    xfer(1'b0, '0, '0, q);
    check(q == '0, "R12 control reads zero", int'(q), 0);

    // R11 table access held by packet request; R8 grant
    @(negedge clk);
    pkt_req = 1'b1; req = 1'b1; we = 1'b0; addr = tbl(3);
    #1;
    check(pkt_gnt == 1'b1, "R8 pkt_gnt idle", int'(pkt_gnt), 1);
    check(ready == 1'b0, "R11 table held by pkt_req", int'(ready), 0);
    pkt_req = 1'b0;
    #1;
    check(ready == 1'b1, "R11 table free", int'(ready), 1);
    req = 1'b0;

    // first wipe: R2, R3, R1
    xfer(1'b1, '0, EW'(1), q);
    measure_clear(n, q);
    check(n == CLR_CYCLES, "R2 wipe stall length", n, CLR_CYCLES);
    check(q[0] == 1'b0, "R3 wipe bit reads zero", int'(q[0]), 0);
    check(q[1] == 1'b0, "R5 idle sweep bit", int'(q[1]), 0);
    verify(0, 2, "R1 table zero after wipe");

    // R11 write/read round trip
    fill(0);
    verify(0, 0, "R11 table readback");

    // wipe with pkt_req high: R8 no grant during wipe
    xfer(1'b1, '0, EW'(1), q);
    pkt_req = 1'b1;
    #1;
    check(pkt_gnt == 1'b0, "R8 no grant in wipe", int'(pkt_gnt), 1'b0);
    pkt_req = 1'b0;
    measure_clear(n, q);
    check(n == CLR_CYCLES, "R2 wipe stall length again", n, CLR_CYCLES);
    verify(0, 2, "R1 table zero after second wipe");

    // plain sweep: R5, R6, R4, R7
    fill(0);
    xfer(1'b1, '0, EW'(2), q);
    poll_busy(0, 0, n);
    check(n == 4 * DEPTH, "R6 sweep length", n, 4 * DEPTH);
    xfer(1'b0, '0, '0, q);
    check(q[1] == 1'b0, "R5 sweep bit self clears", int'(q[1]), 0);
    verify(0, 1, "R4 sweep result");
    verify_static(0);

    // stalled sweep: R8
    fill(3);
    xfer(1'b1, '0, EW'(2), q);
    poll_busy(200, 0, n);
    check(n == 4 * DEPTH + 200, "R8 stalled sweep length", n, 4 * DEPTH + 200);
    verify(3, 1, "R8 stalled sweep result");

    // re-command during sweep: R9
    fill(5);
    xfer(1'b1, '0, EW'(2), q);
    poll_busy(0, 100, n);
    check(n == 4 * DEPTH, "R9 repeated command ignored", n, 4 * DEPTH);
    verify(5, 1, "R9 sweep result unchanged");

    // wipe aborts sweep: R10
    fill(6);
    xfer(1'b1, '0, EW'(2), q);
    repeat (50) @(negedge clk);
    xfer(1'b1, '0, EW'(1), q);
    measure_clear(n, q);
    check(n == CLR_CYCLES, "R10 wipe during sweep stall", n, CLR_CYCLES);
    check(q[1] == 1'b0, "R10 sweep aborted", int'(q[1]), 0);
    verify(6, 2, "R10 table zero after abort");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule